// File: doc/BRIEF.md
# Bus Memory Protection Gate

This block sits between a bus interconnect and a single memory target. Every access carries an address and the ID of the master that issued it. The gate compares each access against a small table of programmable regions. For each access it either lets the access reach memory or stops it. When an access is refused, the gate builds the error response itself.

A region is described by four things: a control word, a base address, and two ID match pairs, each made of a value and a mask. The control word holds an enable bit, separate read and write permissions, and a size code. A global control bit chooses how reads are handled.

With speculation on, a read goes to memory in the cycle it is accepted, and only its response is changed by the check. With speculation off, a read waits for the check in the same way a write does, so a refused read never reaches memory. Speculative reads therefore cost one extra cycle over a direct connection, and checked reads and writes cost two.

Top module: `mpg_gate`

## Requirements
- R1: After reset all regions are disabled, speculation is on (the global bit reads 0), `req_ready_o` is 1, and neither `mem_req_o` nor `rsp_valid_o` is asserted.
- R2: Region control word layout: bit 0 enable, bit 1 read permission, bit 2 write permission, bits 7:4 size code k. An enabled region covers the 2^(k+12) bytes that start at its base, and the base is taken as aligned to that size. An address one byte past the end is outside the region.
- R3: A master ID matches a pair when (id & mask) == (value & mask). A region admits the access when either pair A or pair B matches and the region's permission for the access direction is set.
- R4: The lowest-numbered enabled region that contains the address decides the outcome. An address that lies in no enabled region is allowed, and a disabled region has no effect.
- R5: With speculation on, a read appears on the memory port in the cycle it is accepted, with the same address. Its response arrives two cycles later. A refused read gets `rsp_err_o`=1 and read data 0. An allowed read returns the memory data.
- R6: With speculation off, an allowed read appears on the memory port one cycle after acceptance and a refused read never appears there. The response arrives three cycles after acceptance.
- R7: An allowed write appears on the memory port one cycle after acceptance, with its address and data. A refused write never appears there. The write response (`rsp_write_o`=1, data 0) arrives three cycles after acceptance, with `rsp_err_o` set when the write was refused.
- R8: With speculation on, `req_ready_o` is 0 in the cycle after the gate accepted a write or a checked read. This keeps that access from colliding with a speculative read on the memory port.
- R9: Configuration writes use `cfg_sel_i` codes 0 control, 1 base, 2 ID value A, 3 mask A, 4 ID value B, 5 mask B, applied to region `cfg_idx_i`. Code 7 writes the global control, whose bit 0 turns speculation off. A new setting applies to accesses accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_idx_i | input | RIW | Region index for configuration |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Gate can take an access |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | AW | Byte address |
| req_id_i | input | IDW | Requesting master ID |
| req_wdata_i | input | DW | Write data |
| mem_req_o | output | 1 | Access presented to memory |
| mem_write_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid one cycle after a read |
| rsp_valid_o | output | 1 | Response valid |
| rsp_write_o | output | 1 | Response belongs to a write |
| rsp_err_o | output | 1 | Access was refused |
| rsp_rdata_o | output | DW | Read data, 0 on error or write |

## Verification
The bench sweeps addresses at each region's first byte, last word and first byte past the end, together with IDs that match pair A, pair B, both or neither, in both read modes and both directions. It targets the overlap where a lower-numbered region must override a more permissive one. A design with inverted priority or an off-by-one size mask gives the wrong error bit at those edges. It checks that refused checked reads and refused writes never touch memory, that refused speculative reads do reach memory but return zero data, and that responses arrive at the exact cycle, so a missing or extra pipeline register is caught. The back-to-back write-then-read case in speculative mode exposes a gate that would let two accesses drive the memory port in the same cycle.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int SIZE_W     = 4;

  typedef enum logic [2:0] {
    SEL_CTL    = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_IDA    = 3'd2,
    SEL_MSKA   = 3'd3,
    SEL_IDB    = 3'd4,
    SEL_MSKB   = 3'd5,
    SEL_GLOBAL = 3'd7
  } cfg_sel_e;

  typedef struct packed {
    logic [SIZE_W-1:0] k;
    logic              wr;
    logic              rd;
    logic              en;
  } reg_ctl_t;

  function automatic reg_ctl_t unpack_ctl(input logic [31:0] w);
    reg_ctl_t c;
    c.en = w[0];
    c.rd = w[1];
    c.wr = w[2];
    c.k  = w[7:4];
    return c;
  endfunction
endpackage

// File: rtl/mpg_region_file.sv
module mpg_region_file
  import mpg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int AW          = 32,
  parameter int IDW         = 8,
  localparam int RIW        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [2:0]     cfg_sel_i,
  input  logic [RIW-1:0] cfg_idx_i,
  input  logic [31:0]    cfg_wdata_i,
  output reg_ctl_t       ctl_o  [NUM_REGIONS],
  output logic [AW-1:0]  base_o [NUM_REGIONS],
  output logic [IDW-1:0] ida_o  [NUM_REGIONS],
  output logic [IDW-1:0] mska_o [NUM_REGIONS],
  output logic [IDW-1:0] idb_o  [NUM_REGIONS],
  output logic [IDW-1:0] mskb_o [NUM_REGIONS],
  output logic           spec_dis_o
);
  cfg_sel_e sel;
  logic     unused_cfg;

  assign sel        = cfg_sel_e'(cfg_sel_i);
  assign unused_cfg = ^cfg_wdata_i;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
    logic hit_idx;
    assign hit_idx = cfg_we_i && (cfg_idx_i == RIW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[i]  <= '0;
        base_o[i] <= '0;
        ida_o[i]  <= '0;
        mska_o[i] <= '0;
        idb_o[i]  <= '0;
        mskb_o[i] <= '0;
      end else if (hit_idx) begin
        case (sel)
          SEL_CTL:  ctl_o[i]  <= unpack_ctl(cfg_wdata_i);
          SEL_BASE: base_o[i] <= cfg_wdata_i[AW-1:0];
          SEL_IDA:  ida_o[i]  <= cfg_wdata_i[IDW-1:0];
          SEL_MSKA: mska_o[i] <= cfg_wdata_i[IDW-1:0];
          SEL_IDB:  idb_o[i]  <= cfg_wdata_i[IDW-1:0];
          SEL_MSKB: mskb_o[i] <= cfg_wdata_i[IDW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              spec_dis_o <= 1'b0;
    else if (cfg_we_i && sel == SEL_GLOBAL)   spec_dis_o <= cfg_wdata_i[0];
  end
endmodule

// File: rtl/mpg_check.sv
module mpg_check
  import mpg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int AW          = 32,
  parameter int IDW         = 8
) (
  input  reg_ctl_t       ctl_i  [NUM_REGIONS],
  input  logic [AW-1:0]  base_i [NUM_REGIONS],
  input  logic [IDW-1:0] ida_i  [NUM_REGIONS],
  input  logic [IDW-1:0] mska_i [NUM_REGIONS],
  input  logic [IDW-1:0] idb_i  [NUM_REGIONS],
  input  logic [IDW-1:0] mskb_i [NUM_REGIONS],
  input  logic [AW-1:0]  addr_i,
  input  logic [IDW-1:0] id_i,
  input  logic           write_i,
  output logic           allow_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [NUM_REGIONS-1:0] hit, grant;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
    logic [5:0]    sh;
    logic [AW-1:0] hi_mask;
    logic          id_ok, perm;

    assign sh      = 6'(ctl_i[i].k) + 6'(PAGE_SHIFT);
    assign hi_mask = ~((ONE << sh) - ONE);
    assign hit[i]  = ctl_i[i].en && (((addr_i ^ base_i[i]) & hi_mask) == '0);
    assign id_ok   = ((id_i & mska_i[i]) == (ida_i[i] & mska_i[i])) ||
                     ((id_i & mskb_i[i]) == (idb_i[i] & mskb_i[i]));
    assign perm    = write_i ? ctl_i[i].wr : ctl_i[i].rd;
    assign grant[i] = id_ok && perm;
  end

  // lowest index wins: scan high to low, last hit overrides
  always_comb begin
    allow_o = 1'b1;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) allow_o = grant[i];
    end
  end
endmodule

// File: rtl/mpg_gate.sv
module mpg_gate
  import mpg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int IDW         = 8,
  localparam int RIW        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [2:0]     cfg_sel_i,
  input  logic [RIW-1:0] cfg_idx_i,
  input  logic [31:0]    cfg_wdata_i,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_write_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [IDW-1:0] req_id_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           mem_req_o,
  output logic           mem_write_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           rsp_valid_o,
  output logic           rsp_write_o,
  output logic           rsp_err_o,
  output logic [DW-1:0]  rsp_rdata_o
);
  reg_ctl_t       ctl  [NUM_REGIONS];
  logic [AW-1:0]  base [NUM_REGIONS];
  logic [IDW-1:0] ida  [NUM_REGIONS];
  logic [IDW-1:0] mska [NUM_REGIONS];
  logic [IDW-1:0] idb  [NUM_REGIONS];
  logic [IDW-1:0] mskb [NUM_REGIONS];
  logic           spec_dis;
  logic           allow;

  mpg_region_file #(.NUM_REGIONS(NUM_REGIONS), .AW(AW), .IDW(IDW)) u_rf (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_idx_i, .cfg_wdata_i,
    .ctl_o(ctl), .base_o(base), .ida_o(ida), .mska_o(mska),
    .idb_o(idb), .mskb_o(mskb), .spec_dis_o(spec_dis)
  );

  mpg_check #(.NUM_REGIONS(NUM_REGIONS), .AW(AW), .IDW(IDW)) u_chk_logic (
    .ctl_i(ctl), .base_i(base), .ida_i(ida), .mska_i(mska),
    .idb_i(idb), .mskb_i(mskb),
    .addr_i(req_addr_i), .id_i(req_id_i), .write_i(req_write_i),
    .allow_o(allow)
  );

  logic          accept, spec_rd, to_stage;
  logic          stg_valid, stg_write, stg_allow;
  logic [AW-1:0] stg_addr;
  logic [DW-1:0] stg_wdata;
  logic          p1_valid, p1_write, p1_err;

  // a staged access owns the memory port next cycle; hold off speculative reads
  assign req_ready_o = !(stg_valid && !spec_dis);
  assign accept      = req_valid_i && req_ready_o;
  assign spec_rd     = accept && !req_write_i && !spec_dis;
  assign to_stage    = accept && !spec_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_valid <= 1'b0;
      stg_write <= 1'b0;
      stg_allow <= 1'b0;
      stg_addr  <= '0;
      stg_wdata <= '0;
    end else begin
      stg_valid <= to_stage;
      if (to_stage) begin
        stg_write <= req_write_i;
        stg_allow <= allow;
        stg_addr  <= req_addr_i;
        stg_wdata <= req_wdata_i;
      end
    end
  end

  assign mem_req_o   = spec_rd || (stg_valid && stg_allow);
  assign mem_write_o = !spec_rd && stg_write;
  assign mem_addr_o  = spec_rd ? req_addr_i : stg_addr;
  assign mem_wdata_o = stg_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_valid <= 1'b0;
      p1_write <= 1'b0;
      p1_err   <= 1'b0;
    end else if (spec_rd) begin
      p1_valid <= 1'b1;
      p1_write <= 1'b0;
      p1_err   <= !allow;
    end else begin
      p1_valid <= stg_valid;
      p1_write <= stg_write;
      p1_err   <= !stg_allow;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_write_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= p1_valid;
      rsp_write_o <= p1_valid && p1_write;
      rsp_err_o   <= p1_valid && p1_err;
      rsp_rdata_o <= (p1_valid && !p1_write && !p1_err) ? mem_rdata_i : '0;
    end
  end
endmodule

// File: rtl/mpg_gate_chk.sv
module mpg_gate_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic          spec_dis,
  input logic          mem_req_o,
  input logic          mem_write_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rsp_valid_o,
  input logic          rsp_write_o,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_rdata_o
);
  logic spec_acc, chk_acc, wr_acc;
  assign spec_acc = req_valid_i && req_ready_o && !req_write_i && !spec_dis;
  assign chk_acc  = req_valid_i && req_ready_o && (req_write_i || spec_dis);
  assign wr_acc   = req_valid_i && req_ready_o && req_write_i;

  p_spec_fwd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_acc |-> (mem_req_o && !mem_write_o && mem_addr_o == req_addr_i));

  p_spec_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_acc |-> ##2 (rsp_valid_o && !rsp_write_o));

  p_err_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0));

  p_wr_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |-> ##3 (rsp_valid_o && rsp_write_o));

  p_blk_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_write_o && rsp_err_o) |-> !$past(mem_req_o, 2));

  p_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_acc |=> (!req_ready_o || spec_dis));
endmodule

bind mpg_gate mpg_gate_chk #(.AW(AW), .DW(DW)) u_gate_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .spec_dis(spec_dis), .mem_req_o(mem_req_o),
  .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o),
  .rsp_valid_o(rsp_valid_o), .rsp_write_o(rsp_write_o),
  .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o)
);

// File: tb/mpg_gate_test.sv
module mpg_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [1:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [7:0]  req_id_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        mem_req_o, mem_write_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        rsp_valid_o, rsp_write_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;

  mpg_gate uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // memory: read data one cycle after a read request
  always @(posedge clk_i)
    mem_rdata_i <= (mem_req_o && !mem_write_o) ? ~mem_addr_o : 32'hDEAD_BEEF;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int n_mem, mem_cyc, n_rsp, rsp_cyc;
  logic mem_w, rsp_w, rsp_e;
  logic [31:0] mem_a, mem_d, rsp_d;

  always @(negedge clk_i) begin
    if (mem_req_o) begin
      n_mem++; mem_cyc = cyc; mem_w = mem_write_o; mem_a = mem_addr_o; mem_d = mem_wdata_o;
    end
    if (rsp_valid_o) begin
      n_rsp++; rsp_cyc = cyc; rsp_w = rsp_write_o; rsp_e = rsp_err_o; rsp_d = rsp_rdata_o;
    end
  end

  // bench copy of configuration, used for the arithmetic model
  logic        m_en[NR], m_rd[NR], m_wr[NR];
  int          m_k[NR];
  logic [31:0] m_base[NR];
  logic [7:0]  m_ida[NR], m_mska[NR], m_idb[NR], m_mskb[NR];
  logic        m_spec_dis;

  function automatic logic exp_allow(logic w, logic [31:0] a, logic [7:0] id);
    for (int i = 0; i < NR; i++) begin
      if (m_en[i] && ((a ^ m_base[i]) >> (m_k[i] + 12)) == 0) begin
        return (((id & m_mska[i]) == (m_ida[i] & m_mska[i])) ||
                ((id & m_mskb[i]) == (m_idb[i] & m_mskb[i]))) && (w ? m_wr[i] : m_rd[i]);
      end
    end
    return 1'b1;
  endfunction

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic cfg(logic [2:0] sel, int idx, logic [31:0] d);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = 2'(idx); cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic set_region(int i, logic en, logic rd, logic wr, int k, logic [31:0] b,
                            logic [7:0] ia, logic [7:0] ma, logic [7:0] ib, logic [7:0] mb);
    m_en[i] = en; m_rd[i] = rd; m_wr[i] = wr; m_k[i] = k; m_base[i] = b;
    m_ida[i] = ia; m_mska[i] = ma; m_idb[i] = ib; m_mskb[i] = mb;
    cfg(3'd1, i, b); cfg(3'd2, i, 32'(ia)); cfg(3'd3, i, 32'(ma));
    cfg(3'd4, i, 32'(ib)); cfg(3'd5, i, 32'(mb));
    cfg(3'd0, i, {24'd0, 4'(k), 1'b0, wr, rd, en});
  endtask

  task automatic set_mode(logic dis);
    m_spec_dis = dis;
    cfg(3'd7, 0, {31'd0, dis});
  endtask

  task automatic access(logic w, logic [31:0] a, logic [7:0] id, string rq);
    int c0;
    logic al;
    logic [31:0] wd;
    al = exp_allow(w, a, id);
    wd = a ^ {24'h00C3A5, id};
    @(posedge clk_i); #1;
    n_mem = 0; n_rsp = 0;
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_id_i = id; req_wdata_i = wd;
    while (!req_ready_o) begin @(posedge clk_i); #1; end
    c0 = cyc;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    repeat (5) @(posedge clk_i);
    #1;
    check(rsp_e == !al, rq, 32'(rsp_e), 32'(!al));
    check(n_rsp == 1, "R7 one response", n_rsp, 1);
    if (!w && !m_spec_dis) begin
      check(n_mem == 1 && mem_cyc == c0 && !mem_w && mem_a == a, "R5 forward",
            mem_cyc - c0, 0);
      check(rsp_cyc == c0 + 2 && !rsp_w, "R5 latency", rsp_cyc - c0, 2);
      check(rsp_d == (al ? ~a : 32'd0), "R5 data", rsp_d, al ? ~a : 32'd0);
    end else if (!w) begin
      check(n_mem == int'(al) && (!al || (mem_cyc == c0 + 1 && !mem_w && mem_a == a)),
            "R6 forward", n_mem, 32'(al));
      check(rsp_cyc == c0 + 3 && !rsp_w, "R6 latency", rsp_cyc - c0, 3);
      check(rsp_d == (al ? ~a : 32'd0), "R6 data", rsp_d, al ? ~a : 32'd0);
    end else begin
      check(n_mem == int'(al) && (!al || (mem_cyc == c0 + 1 && mem_w && mem_a == a &&
            mem_d == wd)), "R7 forward", n_mem, 32'(al));
      check(rsp_cyc == c0 + 3 && rsp_w && rsp_d == 0, "R7 latency", rsp_cyc - c0, 3);
    end
  endtask

  logic [31:0] addrs[10] = '{32'h0, 32'hFFC, 32'h1000, 32'hFFFC, 32'h10000,
                             32'h100000, 32'h101FFC, 32'h102000, 32'h200010, 32'h300000};
  logic [7:0]  ids[6] = '{8'h10, 8'h1F, 8'h05, 8'h03, 8'h23, 8'h00};

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_en[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_k[i] = 0; m_base[i] = 0;
      m_ida[i] = 0; m_mska[i] = 0; m_idb[i] = 0; m_mskb[i] = 0;
    end
    m_spec_dis = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(req_ready_o == 1'b1, "R1 ready", 32'(req_ready_o), 1);
    check(!mem_req_o && !rsp_valid_o, "R1 idle", {mem_req_o, rsp_valid_o}, 0);
    access(1'b0, 32'h0000_4000, 8'h77, "R1 default allow");
    access(1'b1, 32'h0000_4000, 8'h77, "R1 default allow");

    // R9 configuration of the region table
    set_region(0, 1, 1, 1, 0, 32'h0000_0000, 8'h10, 8'hF0, 8'h05, 8'hFF);
    set_region(1, 1, 1, 0, 4, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h00);
    set_region(2, 1, 0, 1, 1, 32'h0010_0000, 8'h03, 8'h03, 8'hFF, 8'hFF);
    set_region(3, 0, 0, 0, 2, 32'h0020_0000, 8'hFF, 8'hFF, 8'hFF, 8'hFF);

    // R2 size boundaries, R3 pair matching
    access(1'b1, 32'h0000_0FFC, 8'h1A, "R2 last word in region 0");
    access(1'b1, 32'h0000_1000, 8'h1A, "R2 first byte past region 0");
    access(1'b1, 32'h0010_2000, 8'h07, "R2 past region 2");
    access(1'b1, 32'h0000_0100, 8'h05, "R3 pair B exact");
    access(1'b1, 32'h0000_0100, 8'h06, "R3 no pair");
    access(1'b1, 32'h0010_0000, 8'hF3, "R3 masked pair A");

    for (int md = 0; md < 2; md++) begin
      set_mode(md[0]);
      for (int ai = 0; ai < 10; ai++)
        for (int ii = 0; ii < 6; ii++)
          for (int w = 0; w < 2; w++)
            access(w[0], addrs[ai], ids[ii], "R4 decision");
    end

    // R8 write then read back to back in speculative mode
    set_mode(1'b0);
    @(posedge clk_i); #1;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 32'h0000_0200; req_id_i = 8'h10;
    @(posedge clk_i); #1;
    req_write_i = 1'b0;
    check(req_ready_o == 1'b0, "R8 ready low after write", 32'(req_ready_o), 0);
    @(posedge clk_i); #1;
    check(req_ready_o == 1'b1, "R8 ready back", 32'(req_ready_o), 1);
    req_valid_i = 1'b0;
    repeat (6) @(posedge clk_i);

    // R9 disabling region 0 exposes region 1, which refuses writes
    m_en[0] = 1'b0;
    cfg(3'd0, 0, 32'h0000_0006);
    access(1'b1, 32'h0000_0200, 8'h10, "R9 region disable");
    access(1'b0, 32'h0000_0200, 8'h10, "R9 region disable");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule